// File: doc/BRIEF.md
# Low-Order Path Signal Label Monitor

This block watches the 3-bit signal label that arrives once per multiframe in the path overhead of a single low-order virtual tributary. Each label sample comes with a one-cycle valid strobe. A sample only replaces the accepted label once it has repeated for a programmable number of consecutive samples. This persistence filter stops isolated corrupted labels from reaching the alarm logic.

Two alarms are derived from the accepted label. The unequipped alarm is raised when the accepted label is all zeros. The label-mismatch alarm is raised when the accepted label differs from a software-programmed expected label. Mismatch detection is switched off while the expected label is the "equipped, non-specific" code or while the path is unequipped.

Every alarm transition sets a sticky change bit. Software clears a change bit by writing 1 to it. Each change bit has its own mask, and one interrupt line gathers the unmasked change bits. The unequipped status also leaves the block on its own pin, for use by alarm-insertion logic elsewhere.

Top module: `lo_label_mon`

## Requirements
- R1: On a `lbl_vld` cycle, a sample that differs from the previous valid sample restarts the run count at 1, and a matching sample increments it (saturating at 15). `acc_lbl` takes the sample on the clock edge where the run count reaches the threshold `persist_n`. Samples presented while `lbl_vld` is low have no effect on the count or on `acc_lbl`.
- R2: A threshold `persist_n` of 0 behaves as a threshold of 1, so one sample is enough to be accepted.
- R3: After reset, `acc_lbl` is 000, and `uneq`, `plm`, `uneq_dlt`, `plm_dlt` and `irq` are all 0. Both alarms stay at 0 until a first label has been accepted.
- R4: Once a label has been accepted, `uneq` is 1 exactly when the accepted label is 000. It is updated one clock after `acc_lbl` changes.
- R5: `plm` is 1 when the accepted label differs from `exp_lbl` and detection is enabled. It is updated one clock after `acc_lbl` or `exp_lbl` changes.
- R6: `plm` is held at 0 while `exp_lbl` equals 001 or `uneq` would be 1.
- R7: Every change of `uneq`, whether rising or falling, sets `uneq_dlt` in the same clock in which `uneq` changes.
- R8: Every change of `plm` sets `plm_dlt` in the same clock in which `plm` changes. A change bit is never set when its alarm does not change.
- R9: A change bit stays set until its clear input (`clr_uneq` or `clr_plm`) is high at a clock edge. If a set and a clear arrive in the same cycle, the set wins.
- R10: `irq` is combinationally high when `uneq_dlt` is set with `mask_uneq` low, or when `plm_dlt` is set with `mask_plm` low. Otherwise `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lbl_vld | input | 1 | Strobe marking a new label sample |
| lbl_in | input | 3 | Received label sample |
| persist_n | input | 4 | Consecutive-sample threshold (0 behaves as 1) |
| exp_lbl | input | 3 | Expected label |
| mask_uneq | input | 1 | 1 blocks `uneq_dlt` from the interrupt |
| mask_plm | input | 1 | 1 blocks `plm_dlt` from the interrupt |
| clr_uneq | input | 1 | Write-1 clear for `uneq_dlt` |
| clr_plm | input | 1 | Write-1 clear for `plm_dlt` |
| acc_lbl | output | 3 | Accepted (filtered) label |
| uneq | output | 1 | Unequipped status, also feeds alarm insertion |
| plm | output | 1 | Label mismatch status |
| uneq_dlt | output | 1 | Sticky change bit for `uneq` |
| plm_dlt | output | 1 | Sticky change bit for `plm` |
| irq | output | 1 | Interrupt, OR of the unmasked change bits |

## Verification
The filter is driven with several kinds of label runs, and each kind separates a different fault:

- Runs one sample short of the threshold catch a threshold that is off by one.
- A run broken by a single different sample catches a counter that fails to restart.
- Garbage placed on `lbl_in` between strobes catches a filter that samples without `lbl_vld`.
- Thresholds of 0, 1 and 15 pin down the clamping at both ends of the range.

The alarm logic is checked in three ways:

- Stepping `exp_lbl` through a matching value, a different value and 001 separates true mismatch from suppressed mismatch.
- An accepted 000 label shows that the unequipped condition overrides the mismatch.
- Clearing a change bit in the same cycle that its alarm flips shows whether set takes priority over clear.

// File: rtl/lbl_pkg.sv
// Package: shared constants for the low-order label monitor.
// Assumes one monitored tributary; the condition index orders the change-bit vector.
package lbl_pkg;
    localparam int LBL_W    = 3;
    localparam int CNT_W    = 4;
    localparam int NUM_COND = 2;

    typedef enum int {
        COND_UNEQ = 0,
        COND_PLM  = 1
    } cond_e;
endpackage

// File: rtl/lbl_persist.sv
// Module: persistence filter for the incoming label.
// Assumes lbl_vld marks one sample per multiframe; other cycles are ignored.
// A sample is accepted when it has been seen need_n consecutive valid times.
module lbl_persist #(
    parameter int LW = 3,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld,
    input  logic [LW-1:0] lbl,
    input  logic [CW-1:0] persist_n,
    output logic [LW-1:0] acc_lbl,
    output logic          acc_seen
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
    localparam logic [CW-1:0] CNT_ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [LW-1:0] prev_lbl;
    logic [CW-1:0] run_cnt;
    logic [CW-1:0] run_nx;
    logic [CW-1:0] need_n;
    logic          take;

    // Purpose: clamp threshold, compute next run length and the accept decision.
    always_comb begin
        need_n = (persist_n == '0) ? CNT_ONE : persist_n;
        if (run_cnt == '0 || lbl != prev_lbl)
            run_nx = CNT_ONE;
        else if (run_cnt == CNT_MAX)
            run_nx = CNT_MAX;
        else
            run_nx = run_cnt + CNT_ONE;
        take = (run_nx >= need_n) && (!acc_seen || lbl != acc_lbl);
    end

    // Purpose: update run tracking and accepted label on valid samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lbl <= '0;
            run_cnt  <= '0;
            acc_lbl  <= '0;
            acc_seen <= 1'b0;
        end else if (vld) begin
            prev_lbl <= lbl;
            run_cnt  <= run_nx;
            if (take) begin
                acc_lbl  <= lbl;
                acc_seen <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lbl_alarm.sv
// Module: derives unequipped and mismatch status from the accepted label.
// Assumes acc_seen is 0 until a first label is accepted; alarms stay 0 before that.
// Exposes both the registered status and its next value for change detection.
module lbl_alarm #(
    parameter int              LW      = 3,
    parameter logic [LW-1:0]   PLM_OFF = 3'b001
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] acc_lbl,
    input  logic          acc_seen,
    input  logic [LW-1:0] exp_lbl,
    output logic          uneq_nx,
    output logic          plm_nx,
    output logic          uneq_q,
    output logic          plm_q
);
    // Purpose: next alarm values, mismatch suppressed by PLM_OFF or unequipped.
    always_comb begin
        uneq_nx = acc_seen && (acc_lbl == '0);
        plm_nx  = acc_seen && !uneq_nx && (exp_lbl != PLM_OFF) && (acc_lbl != exp_lbl);
    end

    // Purpose: register alarm status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uneq_q <= 1'b0;
            plm_q  <= 1'b0;
        end else begin
            uneq_q <= uneq_nx;
            plm_q  <= plm_nx;
        end
    end
endmodule

// File: rtl/lbl_delta.sv
// Module: sticky change bits with write-1 clear, per-bit mask and one interrupt.
// Assumes cond_nx/cond_q are the next and current values of each alarm.
// A set coinciding with a clear keeps the bit set.
module lbl_delta #(
    parameter int NC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NC-1:0] cond_nx,
    input  logic [NC-1:0] cond_q,
    input  logic [NC-1:0] clr,
    input  logic [NC-1:0] mask,
    output logic [NC-1:0] dlt,
    output logic          irq
);
    genvar gi;
    generate
        for (gi = 0; gi < NC; gi++) begin : g_cond
            // Purpose: hold one change bit, set on alarm edge, clear on write-1.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    dlt[gi] <= 1'b0;
                else
                    dlt[gi] <= (dlt[gi] & ~clr[gi]) | (cond_nx[gi] ^ cond_q[gi]);
            end
        end
    endgenerate

    // Purpose: gather unmasked change bits into the interrupt.
    always_comb irq = |(dlt & ~mask);
endmodule

// File: rtl/lo_label_mon.sv
// Module: top of the low-order path label monitor.
// Assumes synchronous active-low reset and one label sample per strobe.
// Chains persistence filter, alarm evaluation and change/interrupt logic.
module lo_label_mon
    import lbl_pkg::*;
#(
    parameter logic [LBL_W-1:0] PLM_OFF = 3'b001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lbl_vld,
    input  logic [LBL_W-1:0] lbl_in,
    input  logic [CNT_W-1:0] persist_n,
    input  logic [LBL_W-1:0] exp_lbl,
    input  logic             mask_uneq,
    input  logic             mask_plm,
    input  logic             clr_uneq,
    input  logic             clr_plm,
    output logic [LBL_W-1:0] acc_lbl,
    output logic             uneq,
    output logic             plm,
    output logic             uneq_dlt,
    output logic             plm_dlt,
    output logic             irq
);
    logic                acc_seen;
    logic                uneq_nx;
    logic                plm_nx;
    logic [NUM_COND-1:0] c_nx, c_q, c_clr, c_mask, c_dlt;

    lbl_persist #(.LW(LBL_W), .CW(CNT_W)) i_persist (
        .clk(clk), .rst_n(rst_n), .vld(lbl_vld), .lbl(lbl_in),
        .persist_n(persist_n), .acc_lbl(acc_lbl), .acc_seen(acc_seen)
    );

    lbl_alarm #(.LW(LBL_W), .PLM_OFF(PLM_OFF)) i_alarm (
        .clk(clk), .rst_n(rst_n), .acc_lbl(acc_lbl), .acc_seen(acc_seen),
        .exp_lbl(exp_lbl), .uneq_nx(uneq_nx), .plm_nx(plm_nx),
        .uneq_q(uneq), .plm_q(plm)
    );

    // Purpose: pack per-condition signals in condition-index order.
    always_comb begin
        c_nx[COND_UNEQ]   = uneq_nx;
        c_nx[COND_PLM]    = plm_nx;
        c_q[COND_UNEQ]    = uneq;
        c_q[COND_PLM]     = plm;
        c_clr[COND_UNEQ]  = clr_uneq;
        c_clr[COND_PLM]   = clr_plm;
        c_mask[COND_UNEQ] = mask_uneq;
        c_mask[COND_PLM]  = mask_plm;
        uneq_dlt          = c_dlt[COND_UNEQ];
        plm_dlt           = c_dlt[COND_PLM];
    end

    lbl_delta #(.NC(NUM_COND)) i_delta (
        .clk(clk), .rst_n(rst_n), .cond_nx(c_nx), .cond_q(c_q),
        .clr(c_clr), .mask(c_mask), .dlt(c_dlt), .irq(irq)
    );
endmodule

// File: rtl/lo_label_mon_chk.sv
// Module: property checker for lo_label_mon, attached by bind.
// Assumes the port names of the top module; observes only.
module lo_label_mon_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lbl_vld,
    input logic [2:0] lbl_in,
    input logic [2:0] exp_lbl,
    input logic       mask_uneq,
    input logic       mask_plm,
    input logic       clr_uneq,
    input logic       clr_plm,
    input logic [2:0] acc_lbl,
    input logic       uneq,
    input logic       plm,
    input logic       uneq_dlt,
    input logic       plm_dlt,
    input logic       irq
);
    // R1: accepted label only moves on a strobe, to the strobed sample
    a_r1_acc_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc_lbl) |-> ($past(lbl_vld) && acc_lbl == $past(lbl_in)));

    // R4: unequipped reflects an all-zero accepted label
    a_r4_uneq_zero: assert property (@(posedge clk) disable iff (!rst_n)
        uneq |-> $past(acc_lbl) == 3'b000);

    // R6: mismatch never coexists with unequipped
    a_r6_plm_not_uneq: assert property (@(posedge clk) disable iff (!rst_n)
        plm |-> !uneq);

    // R6: mismatch off while the expected label is 001
    a_r6_plm_off_code: assert property (@(posedge clk) disable iff (!rst_n)
        plm |-> $past(exp_lbl) != 3'b001);

    // R7: unequipped edge sets its change bit
    a_r7_uneq_delta: assert property (@(posedge clk) disable iff (!rst_n)
        (uneq != $past(uneq)) |-> uneq_dlt);

    // R8: mismatch edge sets its change bit
    a_r8_plm_delta: assert property (@(posedge clk) disable iff (!rst_n)
        (plm != $past(plm)) |-> plm_dlt);

    // R9: change bits are sticky without a clear
    a_r9_uneq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (uneq_dlt && !clr_uneq) |=> uneq_dlt);
    a_r9_plm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (plm_dlt && !clr_plm) |=> plm_dlt);

    // R10: interrupt follows unmasked change bits
    a_r10_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((uneq_dlt && !mask_uneq) || (plm_dlt && !mask_plm)) |-> irq);
    a_r10_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((!uneq_dlt || mask_uneq) && (!plm_dlt || mask_plm)) |-> !irq);
endmodule

bind lo_label_mon lo_label_mon_chk i_chk (.*);

// File: tb/test_lo_label_mon.sv
module test_lo_label_mon;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lbl_vld = 1'b0;
    logic [2:0] lbl_in = '0;
    logic [3:0] persist_n = 4'd3;
    logic [2:0] exp_lbl = 3'd3;
    logic       mask_uneq = 1'b0, mask_plm = 1'b0;
    logic       clr_uneq = 1'b0, clr_plm = 1'b0;
    logic [2:0] acc_lbl;
    logic       uneq, plm, uneq_dlt, plm_dlt, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lo_label_mon i_lo_label_mon (.*);

    // Vector fields: {sample, expected label, acc, uneq, plm}; threshold 3.
    localparam int NV = 14;
    localparam logic [10:0] VEC [NV] = '{
        {3'd5, 3'd3, 3'd0, 1'b0, 1'b0},
        {3'd5, 3'd3, 3'd0, 1'b0, 1'b0},
        {3'd5, 3'd3, 3'd5, 1'b0, 1'b1},
        {3'd3, 3'd3, 3'd5, 1'b0, 1'b1},
        {3'd3, 3'd3, 3'd5, 1'b0, 1'b1},
        {3'd3, 3'd3, 3'd3, 1'b0, 1'b0},
        {3'd0, 3'd3, 3'd3, 1'b0, 1'b0},
        {3'd0, 3'd3, 3'd3, 1'b0, 1'b0},
        {3'd0, 3'd3, 3'd0, 1'b1, 1'b0},
        {3'd4, 3'd3, 3'd0, 1'b1, 1'b0},
        {3'd0, 3'd3, 3'd0, 1'b1, 1'b0},
        {3'd4, 3'd3, 3'd0, 1'b1, 1'b0},
        {3'd4, 3'd3, 3'd0, 1'b1, 1'b0},
        {3'd4, 3'd3, 3'd4, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // One strobed sample, garbage between strobes, sample after status settles.
    task automatic send(input logic [2:0] v);
        @(negedge clk);
        lbl_vld = 1'b1;
        lbl_in  = v;
        @(negedge clk);
        lbl_vld = 1'b0;
        lbl_in  = ~v;
        @(negedge clk);
    endtask

    task automatic pulse_clr(input logic u, input logic p);
        @(negedge clk);
        clr_uneq = u;
        clr_plm  = p;
        @(negedge clk);
        clr_uneq = 1'b0;
        clr_plm  = 1'b0;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog run hung actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 reset state
        chk("R3", "acc_lbl", acc_lbl, 0);
        chk("R3", "uneq", uneq, 0);
        chk("R3", "plm", plm, 0);
        chk("R3", "deltas", {uneq_dlt, plm_dlt}, 0);
        chk("R3", "irq", irq, 0);

        // R1 R4 R5 R6 table walk
        for (int i = 0; i < NV; i++) begin
            exp_lbl = VEC[i][7:5];
            send(VEC[i][10:8]);
            chk("R1", $sformatf("acc row%0d", i), acc_lbl, VEC[i][4:2]);
            chk("R4", $sformatf("uneq row%0d", i), uneq, VEC[i][1]);
            chk("R5", $sformatf("plm row%0d", i), plm, VEC[i][0]);
        end
        chk("R7", "uneq_dlt after toggles", uneq_dlt, 1);
        chk("R8", "plm_dlt after toggles", plm_dlt, 1);
        chk("R10", "irq unmasked", irq, 1);

        // R10 masking
        @(negedge clk);
        mask_uneq = 1'b1; mask_plm = 1'b1;
        #1 chk("R10", "irq all masked", irq, 0);
        mask_plm = 1'b0;
        #1 chk("R10", "irq plm unmasked", irq, 1);
        mask_uneq = 1'b0;

        // R9 write-1 clear, per bit
        pulse_clr(1'b1, 1'b0);
        chk("R9", "uneq_dlt cleared", uneq_dlt, 0);
        chk("R9", "plm_dlt kept", plm_dlt, 1);
        pulse_clr(1'b0, 1'b1);
        chk("R9", "plm_dlt cleared", plm_dlt, 0);
        chk("R10", "irq none set", irq, 0);

        // R6 expected 001 disables mismatch
        @(negedge clk);
        exp_lbl = 3'd1;
        @(negedge clk);
        chk("R6", "plm with exp 001", plm, 0);
        chk("R8", "plm_dlt on fall", plm_dlt, 1);
        pulse_clr(1'b0, 1'b1);

        // R5 / R8 matching and differing expected labels
        exp_lbl = 3'd4;
        @(negedge clk); @(negedge clk);
        chk("R5", "plm on match", plm, 0);
        chk("R8", "no delta without change", plm_dlt, 0);
        exp_lbl = 3'd6;
        @(negedge clk); @(negedge clk);
        chk("R5", "plm on mismatch", plm, 1);
        chk("R8", "plm_dlt on rise", plm_dlt, 1);
        pulse_clr(1'b0, 1'b1);

        // R9 set beats clear in the same cycle
        @(negedge clk);
        exp_lbl = 3'd4;
        clr_plm = 1'b1;
        @(negedge clk);
        clr_plm = 1'b0;
        chk("R9", "plm falls", plm, 0);
        chk("R9", "set wins over clear", plm_dlt, 1);

        // R2 threshold 0 behaves as 1
        persist_n = 4'd0;
        send(3'd2);
        chk("R2", "acc after one sample", acc_lbl, 2);
        chk("R5", "plm with acc 2 exp 4", plm, 1);

        // R1 threshold 15 boundary
        persist_n = 4'd15;
        for (int k = 0; k < 14; k++) send(3'd7);
        chk("R1", "acc after 14 of 15", acc_lbl, 2);
        send(3'd7);
        chk("R1", "acc after 15 of 15", acc_lbl, 7);

        // R7 R6 unequipped rise with threshold 1
        pulse_clr(1'b1, 1'b1);
        persist_n = 4'd1;
        send(3'd0);
        chk("R4", "uneq on zero label", uneq, 1);
        chk("R6", "plm held by uneq", plm, 0);
        chk("R7", "uneq_dlt on rise", uneq_dlt, 1);

        // R3 reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3", "acc after reset", acc_lbl, 0);
        chk("R3", "status after reset", {uneq, plm}, 0);
        chk("R3", "deltas after reset", {uneq_dlt, plm_dlt}, 0);
        chk("R3", "irq after reset", irq, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule